// File: doc/BRIEF.md
# End-of-Block Run Merger

This block belongs to the second stage of an intra/inter video encoder, where quantized coefficient tokens come back from frame storage in coded order. It finds neighbouring blocks whose remaining AC coefficients are all zero, counts them, and puts one end-of-block run token in their place. Every other coefficient token passes through unchanged. Runs are counted across blocks in coded order rather than inside one block, which is why this step cannot happen while each block is being transformed.

Each input beat is one of two kinds. A "zero block" beat (`in_zero` = 1) stands for a whole block whose remaining AC coefficients are zero. Its token field is ignored. A coefficient beat (`in_zero` = 0) carries a 12-bit token that is forwarded as it is. `in_grp` marks the first beat of a new colour plane or coefficient index group. `in_eof` marks the last beat of a frame. The output carries run tokens and forwarded tokens in order, under a valid/ready handshake, and feeds the entropy coder.

A run token carries three fields:
- a length category in `out_cat`;
- a count of extra bits in `out_xlen`;
- the extra-bit value in `out_tok`.

Top module: `eob_run_merger`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A coefficient beat appears on the output with its token and `in_last` unchanged, `out_is_run` = 0, `out_cat` = 0 and `out_xlen` = 0. When the output register is free, it appears in the cycle after it is accepted.
- R3: A zero-block beat produces no output of its own. It only adds one to the pending run.
- R4: When a coefficient beat arrives while a run is pending, the run token is emitted first, followed by that beat.
- R5: A beat with `in_grp` = 1 flushes any pending run before the beat itself is processed, even when the beat is a zero block.
- R6: A zero-block beat with `in_eof` = 1 is counted, and the run including it is then emitted at once.
- R7: When a run reaches 4095 blocks, it is emitted as one token and counting restarts from zero.
- R8: Run categories are as follows:

  | Run length | `out_cat` | `out_xlen` | `out_tok` |
  |---|---|---|---|
  | 1 | 0 | 0 | 0 |
  | 2 | 1 | 0 | 0 |
  | 3 | 2 | 0 | 0 |
  | 4–7 | 3 | 2 | length − 4 |
  | 8–15 | 4 | 3 | length − 8 |
  | 16–31 | 5 | 4 | length − 16 |
  | 32–4095 | 6 | 12 | the length itself |

  `out_is_run` = 1 on every run token.
- R9: While `out_valid` = 1 and `out_ready` = 0, all output fields hold steady. Under any back-pressure pattern, no token is lost or repeated.
- R10: `in_ready` is 0 in any cycle where the output register cannot be loaded, or where a run is being flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_tok | input | 12 | Coefficient token; ignored on zero-block beats |
| in_last | input | 1 | Last token of a block |
| in_zero | input | 1 | Beat stands for a block with all remaining AC zero |
| in_grp | input | 1 | First beat of a new plane or coefficient group |
| in_eof | input | 1 | Last beat of the frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_tok | output | 12 | Forwarded token, or extra-bit value of a run token |
| out_last | output | 1 | Forwarded block-end marker; 0 on run tokens |
| out_is_run | output | 1 | Beat is an end-of-block run token |
| out_cat | output | 3 | Run length category |
| out_xlen | output | 4 | Number of extra bits for the run token |

## Verification
The bench aims at the band edges (lengths 1, 3, 4, 7, 8, 15, 16, 31, 32). A wrong threshold there would put a run into the neighbouring category or give a negative extra value. It also targets a group change on a zero-block beat and a frame ending on a zero block. A design that missed either of these would merge runs across groups or leave a run stranded until the next frame. A run of 4097 blocks checks the saturation point, where an off-by-one would give a 4096-length wrap or an early split. Random output back-pressure shows whether a run token jumps ahead of, or is lost behind, the coefficient beat that ended it.

// File: rtl/eob_pkg.sv
// Package: shared widths and the output beat record for the run merger.
// Assumes tokens are 12 bits wide and run categories fit in 3 bits.
package eob_pkg;
    localparam int TOK_W  = 12;
    localparam int CAT_W  = 3;
    localparam int XLEN_W = 4;

    // One output beat as held in the output register.
    typedef struct packed {
        logic              is_run;
        logic [CAT_W-1:0]  cat;
        logic [XLEN_W-1:0] xlen;
        logic [TOK_W-1:0]  tok;
        logic              last;
    } out_beat_t;
endpackage

// File: rtl/eob_run_counter.sv
// Run counter: counts accepted zero-block beats. It raises a flush request
// when the count reaches its cap or when the counted beat ends the frame.
// Assumes inc and clr are never asserted in the same cycle.
module eob_run_counter #(
    parameter int RUN_MAX = 4095,
    parameter int CNT_W   = $clog2(RUN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             eof,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flush_req
);
    localparam logic [CNT_W-1:0] CAP_M1 = CNT_W'(RUN_MAX - 1);

    // Count qualifying blocks and latch an immediate-flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            flush_req <= 1'b0;
        end else if (clr) begin
            cnt       <= '0;
            flush_req <= 1'b0;
        end else if (inc) begin
            cnt       <= cnt + 1'b1;
            flush_req <= eof || (cnt == CAP_M1);
        end
    end
endmodule

// File: rtl/eob_run_classify.sv
// Run classifier: maps a run length (1..cap) to a category, an extra-bit
// count and an extra-bit value. Purely combinational.
// Assumes CNT_W is at most the token width.
module eob_run_classify
    import eob_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]  run_len,
    output logic [CAT_W-1:0]  cat,
    output logic [XLEN_W-1:0] xlen,
    output logic [TOK_W-1:0]  xval
);
    logic [TOK_W-1:0] len_w;
    assign len_w = TOK_W'(run_len);

    // Pick the band and compute the offset within it.
    always_comb begin
        cat  = '0;
        xlen = '0;
        xval = '0;
        if (len_w <= TOK_W'(3)) begin
            cat = CAT_W'(len_w - TOK_W'(1));
        end else if (len_w < TOK_W'(8)) begin
            cat  = CAT_W'(3);
            xlen = XLEN_W'(2);
            xval = len_w - TOK_W'(4);
        end else if (len_w < TOK_W'(16)) begin
            cat  = CAT_W'(4);
            xlen = XLEN_W'(3);
            xval = len_w - TOK_W'(8);
        end else if (len_w < TOK_W'(32)) begin
            cat  = CAT_W'(5);
            xlen = XLEN_W'(4);
            xval = len_w - TOK_W'(16);
        end else begin
            cat  = CAT_W'(6);
            xlen = XLEN_W'(CNT_W);
            xval = len_w;
        end
    end
endmodule

// File: rtl/eob_out_stage.sv
// Output register: a single-entry register for output beats with a
// valid/ready handshake. Assumes load is asserted only while free is high.
module eob_out_stage
    import eob_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  out_beat_t din,
    input  logic      out_ready,
    output logic      out_valid,
    output out_beat_t dout,
    output logic      free
);
    assign free = !out_valid || out_ready;

    // Hold a beat until downstream takes it; reload when free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            dout      <= din;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/eob_run_merger.sv
// Top of the end-of-block run merger. Zero-block beats are counted. The
// pending run is emitted as one run token before a coefficient beat, before
// a group start, at end of frame, or at the cap. Coefficient beats pass
// through. Assumes each beat's flags are stable while in_valid is high.
module eob_run_merger
    import eob_pkg::*;
#(
    parameter int RUN_MAX = 4095,
    localparam int CNT_W  = $clog2(RUN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TOK_W-1:0]  in_tok,
    input  logic              in_last,
    input  logic              in_zero,
    input  logic              in_grp,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TOK_W-1:0]  out_tok,
    output logic              out_last,
    output logic              out_is_run,
    output logic [CAT_W-1:0]  out_cat,
    output logic [XLEN_W-1:0] out_xlen
);
    logic [CNT_W-1:0]  cnt;
    logic              flush_req, free, pre_flush, emit_run, in_fire, load;
    logic [CAT_W-1:0]  r_cat;
    logic [XLEN_W-1:0] r_xlen;
    logic [TOK_W-1:0]  r_xval;
    out_beat_t         din, dout;

    // Decide this cycle's action: flush a run, accept a beat, or wait.
    always_comb begin
        pre_flush = in_valid && (cnt != '0) && (!in_zero || in_grp);
        emit_run  = free && (flush_req || pre_flush);
        in_ready  = free && !flush_req && !pre_flush;
        in_fire   = in_valid && in_ready;
        load      = emit_run || (in_fire && !in_zero);
    end

    // Build the beat to load: a run token or a forwarded coefficient.
    always_comb begin
        if (emit_run) begin
            din = '{is_run: 1'b1, cat: r_cat, xlen: r_xlen, tok: r_xval, last: 1'b0};
        end else begin
            din = '{is_run: 1'b0, cat: '0, xlen: '0, tok: in_tok, last: in_last};
        end
    end

    eob_run_counter #(.RUN_MAX(RUN_MAX), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(in_fire && in_zero), .eof(in_eof),
        .clr(emit_run), .cnt(cnt), .flush_req(flush_req)
    );

    eob_run_classify #(.CNT_W(CNT_W)) u_cls (
        .run_len(cnt), .cat(r_cat), .xlen(r_xlen), .xval(r_xval)
    );

    eob_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .din(din),
        .out_ready(out_ready), .out_valid(out_valid), .dout(dout), .free(free)
    );

    // Unpack the output register onto the ports.
    always_comb begin
        out_tok    = dout.tok;
        out_last   = dout.last;
        out_is_run = dout.is_run;
        out_cat    = dout.cat;
        out_xlen   = dout.xlen;
    end
endmodule

// Checker: handshake and encoding properties of the run merger ports.
module eob_run_merger_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [11:0] in_tok,
    input logic        in_last,
    input logic        in_zero,
    input logic        out_valid,
    input logic        out_ready,
    input logic [11:0] out_tok,
    input logic        out_last,
    input logic        out_is_run,
    input logic [2:0]  out_cat,
    input logic [3:0]  out_xlen
);
    // R2: an accepted coefficient beat is the next output, unchanged.
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_zero |=> out_valid && !out_is_run &&
        out_tok == $past(in_tok) && out_last == $past(in_last));

    // R9: a stalled output beat holds all fields.
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tok) &&
        $stable(out_is_run) && $stable(out_cat) && $stable(out_xlen) &&
        $stable(out_last));

    // R10: no input accepted while the output is stalled.
    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R8: category and extra-bit count agree on every run token.
    a_r8_cat_xlen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_run |->
        (out_cat <= 3'd2 && out_xlen == 4'd0 && out_tok == 12'd0) ||
        (out_cat == 3'd3 && out_xlen == 4'd2 && out_tok < 12'd4) ||
        (out_cat == 3'd4 && out_xlen == 4'd3 && out_tok < 12'd8) ||
        (out_cat == 3'd5 && out_xlen == 4'd4 && out_tok < 12'd16) ||
        (out_cat == 3'd6 && out_xlen >= 4'd5 && out_tok >= 12'd32));

    // R8: run tokens never carry a block-end marker.
    a_r8_run_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_run |-> !out_last);
endmodule

bind eob_run_merger eob_run_merger_chk u_chk (.*);

// File: tb/sim_eob_run_merger.sv
// Directed bench for the run merger: one task per scenario, each checking
// its own results against an expected stream built from the requirements.
module sim_eob_run_merger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_zero = 1'b0;
    logic        in_grp = 1'b0, in_eof = 1'b0, out_ready = 1'b1;
    logic [11:0] in_tok = '0;
    logic        in_ready, out_valid, out_last, out_is_run;
    logic [11:0] out_tok;
    logic [2:0]  out_cat;
    logic [3:0]  out_xlen;

    int checks = 0, errors = 0;
    int mcnt = 0;
    bit bp_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [20:0] exp_q[$];
    logic [20:0] got_q[$];

    always #10 clk = ~clk;

    eob_run_merger u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tok(in_tok), .in_last(in_last), .in_zero(in_zero), .in_grp(in_grp),
        .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready),
        .out_tok(out_tok), .out_last(out_last), .out_is_run(out_is_run),
        .out_cat(out_cat), .out_xlen(out_xlen)
    );

    // Expected run token {is_run,cat,xlen,tok,last} from the R8 table.
    function automatic logic [20:0] run_beat(input int len);
        if (len == 1)      return {1'b1, 3'd0, 4'd0, 12'd0, 1'b0};
        else if (len == 2) return {1'b1, 3'd1, 4'd0, 12'd0, 1'b0};
        else if (len == 3) return {1'b1, 3'd2, 4'd0, 12'd0, 1'b0};
        else if (len < 8)  return {1'b1, 3'd3, 4'd2, 12'(len - 4), 1'b0};
        else if (len < 16) return {1'b1, 3'd4, 4'd3, 12'(len - 8), 1'b0};
        else if (len < 32) return {1'b1, 3'd5, 4'd4, 12'(len - 16), 1'b0};
        else               return {1'b1, 3'd6, 4'd12, 12'(len), 1'b0};
    endfunction

    // Output monitor: drives back-pressure and records accepted beats.
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_on ? lfsr[0] : 1'b1;
            #9;
            if (rst_n && out_valid && out_ready)
                got_q.push_back({out_is_run, out_cat, out_xlen, out_tok, out_last});
            if (rst_n && bp_on && out_valid && !out_ready) begin
                checks++;
                if (in_ready) begin
                    errors++;
                    $display("FAIL R10: in_ready=%0b expected 0 during stall", in_ready);
                end
            end
        end
    end

    // Send one beat and update the requirement model.
    task automatic put(input logic [11:0] tok, input logic last, input logic zero,
                       input logic grp, input logic eof);
        bit acc;
        if (mcnt > 0 && (!zero || grp)) begin
            exp_q.push_back(run_beat(mcnt));
            mcnt = 0;
        end
        if (zero) begin
            mcnt++;
            if (mcnt == 4095 || eof) begin
                exp_q.push_back(run_beat(mcnt));
                mcnt = 0;
            end
        end else begin
            exp_q.push_back({1'b0, 3'd0, 4'd0, tok, last});
        end
        in_valid = 1'b1; in_tok = tok; in_last = last;
        in_zero = zero; in_grp = grp; in_eof = eof;
        forever begin
            #9;
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0; in_grp = 1'b0; in_eof = 1'b0; in_zero = 1'b0;
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) put(12'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    // Wait for the output to drain, then compare beat by beat.
    task automatic compare(input string req);
        int n;
        for (int i = 0; i < 400 && got_q.size() < exp_q.size(); i++) @(negedge clk);
        repeat (6) @(negedge clk);
        checks++;
        if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s: beat count %0d expected %0d", req, got_q.size(), exp_q.size());
        end
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            checks++;
            if (got_q[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL %s: beat %0d got %h expected %h", req, i, got_q[i], exp_q[i]);
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    // R1: reset state.
    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
        end
    endtask

    // R2: coefficient beats pass unchanged.
    task automatic t_pass();
        put(12'h123, 1'b0, 1'b0, 1'b0, 1'b0);
        put(12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0);
        put(12'h000, 1'b0, 1'b0, 1'b0, 1'b0);
        put(12'hA5A, 1'b1, 1'b0, 1'b0, 1'b0);
        compare("R2");
    endtask

    // R3, R4, R8: runs at every band edge, each ended by a coefficient.
    task automatic t_bands();
        int lens[10] = '{1, 2, 3, 4, 7, 8, 15, 16, 31, 32};
        foreach (lens[k]) begin
            zeros(lens[k]);
            put(12'(k + 16), 1'b1, 1'b0, 1'b0, 1'b0);
        end
        compare("R8");
        zeros(5);
        put(12'h777, 1'b0, 1'b0, 1'b0, 1'b0);
        put(12'h778, 1'b1, 1'b0, 1'b0, 1'b0);
        compare("R4");
    endtask

    // R5: group start on a zero block splits the run.
    task automatic t_group();
        zeros(3);
        put(12'h0, 1'b1, 1'b1, 1'b1, 1'b0);
        zeros(1);
        put(12'h055, 1'b1, 1'b0, 1'b1, 1'b0);
        compare("R5");
    endtask

    // R6: frame ends on a zero block.
    task automatic t_eof();
        zeros(9);
        put(12'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        compare("R6");
    endtask

    // R7: run saturation at 4095.
    task automatic t_cap();
        zeros(4096);
        put(12'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        compare("R7");
    endtask

    // R9, R10: mixed stream under random back-pressure.
    task automatic t_stall();
        bp_on = 1'b1;
        for (int r = 0; r < 12; r++) begin
            zeros(r % 6);
            put(12'(r * 37), r[0], 1'b0, (r % 4) == 3, 1'b0);
            put(12'(r * 41 + 1), 1'b1, 1'b0, 1'b0, 1'b0);
        end
        zeros(20);
        put(12'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        compare("R9");
        bp_on = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_bands();
        t_group();
        t_eof();
        t_cap();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule